// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a watchdog timer. It counts pulses from a slow tick input and raises a one-cycle reset request when the count reaches a programmable timeout. Software must pulse the kick input often enough to keep the count below that timeout. Turning the watchdog on is a single register write. Turning it off is guarded, so that a program that has run away cannot silence the watchdog by accident.

Control and status sit in one 8-bit register with a single write port (strobe plus data) and a combinational read port. The register has an enable flag, an unlock flag and a 3-bit period select. To clear the enable flag, software first writes a one to the unlock flag and to the enable flag together. It must then write a zero to the enable flag while the unlock flag is still set. The unlock flag clears itself four clock cycles after it is set.

The tick input is a clock enable that comes from a separate slow oscillator. The reset request goes to the system reset logic. That logic, the oscillator and any forced-enable option are outside this block.

Top module: `wdt_guard`

## Requirements
- R1: After reset the register reads 0x00: the watchdog is off, the period select is 0, the unlock flag is clear, and the reset request is low.
- R2: Register bits 7..5 always read zero, and values written to them change nothing.
- R3: Every write loads the period select from bits 2..0. A write with bit 3 (enable) set turns the watchdog on, whatever the state of the unlock flag.
- R4: A write with bit 3 clear leaves the enable flag set when bit 4 (the unlock flag) currently reads zero.
- R5: The unlock flag (bit 4) is set only by a write with bits 4 and 3 both one. Once set, it reads one for exactly four clock cycles and then clears itself. A write with bit 4 set and bit 3 clear does not set it, and writing zero to bit 4 does not clear it early.
- R6: A write that clears bit 3 in any of the four cycles after the unlock write turns the watchdog off. The same write one cycle later is ignored.
- R7: With select value N, the reset request fires after 2^(BASE_LOG2+N) tick cycles counted from zero, where BASE_LOG2 defaults to 14. Cycles with the tick input low do not advance the count.
- R8: The reset request is high for exactly one clock cycle. The count then restarts from zero, and the next request comes one full period later.
- R9: A kick clears the count to zero. A kick in the same cycle as the timeout tick suppresses that request.
- R10: While the watchdog is off, no reset request is produced and the count is held at zero, so turning the watchdog on starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| tick | input | 1 | Clock enable from the slow oscillator |
| kick | input | 1 | Clears the timeout count |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that the smallest timeout is longer than one tick, so two requests are never back to back. This holds whenever BASE_LOG2 is at least 1. They also assume that kick and tick are synchronous, single-cycle-sampled inputs. The bench uses a small BASE_LOG2 of 2 and sweeps all eight select values under two tick patterns: every cycle, and one cycle in three. It also steps the disable write across every offset from one to six cycles after the unlock write. The bench changes inputs only at the falling edge and never writes the register while it is measuring a timeout, so every expected request count is an exact power of two.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W      = 3;
  localparam int NUM_SEL    = 1 << SEL_W;
  localparam int REG_W      = 8;
  localparam int BIT_UNLOCK = 4;
  localparam int BIT_EN     = 3;

  typedef logic [SEL_W-1:0] psel_t;

  typedef struct packed {
    logic  unlock;
    logic  en;
    psel_t sel;
  } ctrl_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int UNLOCK_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_field,
  output ctrl_t       ctrl
);
  localparam int WIN_W = $clog2(UNLOCK_WIN + 1);

  ctrl_t            ctrl_q, ctrl_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             wr_en_bit, wr_unlock_bit;

  assign wr_en_bit     = wr_field[BIT_EN];
  assign wr_unlock_bit = wr_field[BIT_UNLOCK];

  always_comb begin
    ctrl_d = ctrl_q;
    win_d  = win_q;
    // unlock window runs down on its own
    if (ctrl_q.unlock) begin
      if (win_q == WIN_W'(1)) begin
        ctrl_d.unlock = 1'b0;
        win_d         = '0;
      end else begin
        win_d = win_q - WIN_W'(1);
      end
    end
    if (wr_en) begin
      ctrl_d.sel = wr_field[SEL_W-1:0];
      if (wr_en_bit)           ctrl_d.en = 1'b1;
      else if (ctrl_q.unlock)  ctrl_d.en = 1'b0;
      if (wr_en_bit && wr_unlock_bit) begin
        ctrl_d.unlock = 1'b1;
        win_d         = WIN_W'(UNLOCK_WIN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      win_q  <= win_d;
    end
  end

  assign ctrl = ctrl_q;

  // R6: enable may only fall while the unlock window was open
  assert_disable_needs_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.en) |-> $past(ctrl_q.unlock));

  // R5: unlock rises only after a write carrying both flags
  assert_unlock_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.unlock) |-> $past(wr_en && wr_unlock_bit && wr_en_bit));

  // R3: writing the enable bit always turns the watchdog on
  assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_en_bit) |=> ctrl_q.en);

  // R4: clearing without an open window leaves enable set
  assert_locked_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_en_bit && !ctrl_q.unlock && ctrl_q.en) |=> ctrl_q.en);
endmodule

// File: rtl/wdt_period_decode.sv
module wdt_period_decode
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CW        = BASE_LOG2 + NUM_SEL
) (
  input  psel_t         sel,
  output logic [CW-1:0] limit_m1
);
  logic [CW-1:0] lim_tbl [NUM_SEL];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_lim
    assign lim_tbl[i] = ({{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + i)) - CW'(1);
  end

  assign limit_m1 = lim_tbl[sel];
endmodule

// File: rtl/wdt_timeout_counter.sv
module wdt_timeout_counter #(
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          kick,
  input  logic [CW-1:0] limit_m1,
  output logic          req
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          hit;

  assign hit = tick && (cnt_q >= limit_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || kick)  cnt_d = '0;
    else if (tick)    cnt_d = hit ? '0 : cnt_q + CW'(1);
    req_d = en && !kick && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  // R8: a request never lasts two cycles
  assert_req_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R10: a request needs the watchdog on in the cycle before
  assert_req_only_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(en));

  // R10: count is held at zero while off
  assert_off_holds_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  // R9: kick empties the count
  assert_kick_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int UNLOCK_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick,
  input  logic       kick,
  output logic       wdt_rst_req
);
  localparam int CW = BASE_LOG2 + NUM_SEL;

  logic          rst_n_s;
  ctrl_t         ctrl;
  logic [CW-1:0] limit_m1;
  logic [2:0]    rsvd_unused;

  assign rsvd_unused = wr_data[7:5];

  wdt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wdt_ctrl_reg #(.UNLOCK_WIN(UNLOCK_WIN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_field (wr_data[4:0]),
    .ctrl     (ctrl)
  );

  wdt_period_decode #(.BASE_LOG2(BASE_LOG2), .CW(CW)) u_decode (
    .sel      (ctrl.sel),
    .limit_m1 (limit_m1)
  );

  wdt_timeout_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .en       (ctrl.en),
    .tick     (tick),
    .kick     (kick),
    .limit_m1 (limit_m1),
    .req      (wdt_rst_req)
  );

  assign rd_data = {3'b000, ctrl};
endmodule

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       kick = 1'b0;
  logic       wdt_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .kick(kick), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic turn_off();
    wr(8'h18);
    wr(8'h00);
    idle(6);
  endtask

  // ticks driven until the first request (-1 if none within cap)
  task automatic run_to_req(input int pat, output int nt);
    int ticks = 0;
    nt = -1;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      tick = (pat == 0) || (cyc % 3 == 0);
      if (tick) ticks++;
      @(negedge clk);
      if (wdt_rst_req) begin nt = ticks; break; end
    end
    tick = 1'b0;
  endtask

  initial begin
    int nt;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R1 reset register", rd_data, 8'h00);
    check("R1 reset request", wdt_rst_req, 0);

    // R2 / R3: reserved bits ignored, select loaded, enable set
    wr(8'hE5);
    check("R2 reserved ignored, R3 select", rd_data, 8'h05);
    wr(8'hED);
    check("R2 reserved ignored, R3 enable", rd_data, 8'h0D);

    // R4: clear attempts while locked
    wr(8'h02);
    check("R4 locked clear", rd_data, 8'h0A);
    wr(8'h11);
    check("R4/R5 unlock bit alone", rd_data, 8'h09);
    wr(8'h00);
    check("R4 locked clear again", rd_data, 8'h08);

    // R5: unlock lifetime
    wr(8'h1B);
    for (int i = 0; i < 4; i++) begin
      check("R5 unlock visible", rd_data[4], 1);
      wr_en = (i == 1); wr_data = 8'h0B;  // bit4 written zero mid-window
      idle(1);
      wr_en = 1'b0; wr_data = 8'h00;
    end
    check("R5 unlock self-cleared", rd_data[4], 0);
    wr(8'h03);
    check("R6 late clear ignored", rd_data, 8'h0B);

    // R6: sweep the offset of the clearing write
    for (int j = 0; j < 6; j++) begin
      wr(8'h08);
      idle(6);
      wr(8'h18);
      idle(j);
      wr(8'h00);
      check($sformatf("R6 clear after %0d idle", j), rd_data[3], (j <= 3) ? 0 : 1);
      idle(6);
    end

    // R7 / R8: timeout for every select under two tick patterns
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 2; p++) begin
        turn_off();
        check("R10 off before run", rd_data[3], 0);
        wr(8'h08 | 8'(s));
        run_to_req(p, nt);
        check($sformatf("R7 sel=%0d pat=%0d", s, p), nt, 1 << (BASE + s));
        tick = 1'b0;
        idle(1);
        check("R8 request one cycle", wdt_rst_req, 0);
        run_to_req(p, nt);
        check($sformatf("R8 restart sel=%0d pat=%0d", s, p), nt, 1 << (BASE + s));
      end
    end

    // R9: kick clears, and wins over the timeout tick
    turn_off();
    wr(8'h09);
    tick = 1'b1;
    idle(7);
    check("R9 no early request", wdt_rst_req, 0);
    kick = 1'b1;
    idle(1);
    kick = 1'b0; tick = 1'b0;
    check("R9 kick suppresses request", wdt_rst_req, 0);
    run_to_req(0, nt);
    check("R9 full period after kick", nt, 8);
    tick = 1'b1;
    idle(4);
    kick = 1'b1;
    idle(1);
    kick = 1'b0;
    run_to_req(0, nt);
    check("R9 mid-count kick", nt, 8);

    // R10: no request while off
    turn_off();
    begin
      int seen = 0;
      tick = 1'b1;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (wdt_rst_req) seen++;
      end
      tick = 1'b0;
      check("R10 no request while off", seen, 0);
    end
    wr(8'h08);
    run_to_req(0, nt);
    check("R10 enable starts from zero", nt, 4);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule